// File: doc/BRIEF.md
# Guarded Frame Bit Counter

This block tracks how many bits remain in the current frame of a serial shift engine. It serves two framings. In two-wire bus format every frame carries an acknowledge bit after its data bits. In clocked synchronous format the frame carries data bits only. A 3-bit length code selects the frame length, and the same code gives a different length in each format.

A processor reaches the block through a 4-bit register. Bit 3 is a guard bit and bits 2:0 hold the length code. A write changes the code only if that same write carries a 0 in the guard position. The guard bit always reads as 1. During a frame, the code field reads back the bits still left to transfer rather than the programmed value.

The shift engine supplies three inputs: a frame-start pulse, a per-bit strobe and a flag that is high while the clock line is low. The block returns the raw remaining count, the decoded frame length and a one-cycle end-of-frame pulse.

Top module: `serial_bit_counter`

## Requirements
- R1: In bus mode, a write (`wr_en_i`) changes the code field to `wr_data_i[2:0]` only when `wr_data_i[3]` (guard) is 0. A write with the guard at 1 leaves the code unchanged.
- R2: `rd_data_o[3]` always reads 1.
- R3: In bus mode (`mode_bus_i`=1), `frame_len_o` is 9 for code 000 and code+1 for codes 001..111.
- R4: In synchronous mode (`mode_bus_i`=0), `frame_len_o` is 8 for code 000 and equals the code for codes 001..111.
- R5: While a frame is in progress, `rd_data_o[2:0]` shows the remaining bit count mapped back to a code. In bus mode that is the low 3 bits of remaining-1. In synchronous mode it is the low 3 bits of remaining. A full 9-bit bus frame or a full 8-bit synchronous frame therefore reads 000.
- R6: The strobe that takes the remaining count from 1 to 0 returns the code field to 000. On the next cycle `frame_end_o` is 1 for exactly one cycle, and `remaining_o` is 0.
- R7: In bus mode, a write of a nonzero code while `scl_low_i` is 0 is ignored. A write of code 000 is accepted whatever the level of `scl_low_i`.
- R8: In synchronous mode, every write to the code field is ignored.
- R9: During a frame, a write in the same cycle as `bit_strobe_i` is discarded, and the decrement takes place. An accepted write during a frame without a strobe reloads the remaining count with the new decoded length.
- R10: After reset, the code is 000, `remaining_o` is 0 and `frame_end_o` is 0.
- R11: With `remaining_o`=0, `frame_start_i` loads `remaining_o` with the decoded frame length. Each strobe then decrements it by one. A strobe while idle has no effect, and `frame_start_i` during a frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_bus_i | input | 1 | 1 = two-wire bus format, 0 = clocked synchronous format |
| wr_en_i | input | 1 | Register write enable |
| wr_data_i | input | 4 | Write data: bit 3 guard, bits 2:0 length code |
| rd_data_o | output | 4 | Read data: bit 3 always 1, bits 2:0 code or remaining |
| frame_start_i | input | 1 | Start-of-frame pulse from the shift engine |
| bit_strobe_i | input | 1 | One pulse per transferred bit |
| scl_low_i | input | 1 | High while the serial clock line is low |
| remaining_o | output | 4 | Bits left in the current frame, 0 when idle |
| frame_len_o | output | 4 | Frame length decoded from the current code and mode |
| frame_end_o | output | 1 | One-cycle pulse after the last bit of a frame |

## Verification
The bench builds the block with the default code width of 3, so the counter is 4 bits wide. With that width it can reach both longest frames: the 9-bit bus frame, acknowledge bit included, and the 8-bit synchronous frame. It also reaches the case where code 000 stands for the largest length. Under the same width it walks all 16 mode and code pairs through the decoder. It drives both full-length frames to completion and checks the end pulse. It also times writes so that they meet the clock-line guard and a bit strobe in the same cycle.

// File: rtl/ser_cnt_pkg.sv
package ser_cnt_pkg;
  typedef enum logic {MODE_SYNC = 1'b0, MODE_BUS = 1'b1} ser_mode_e;
endpackage

// File: rtl/ser_cnt_len_dec.sv
module ser_cnt_len_dec
  import ser_cnt_pkg::*;
#(
  parameter int CODE_W = 3,
  localparam int CNT_W = CODE_W + 1
) (
  input  ser_mode_e           mode_i,
  input  logic [CODE_W-1:0]   code_i,
  output logic [CNT_W-1:0]    len_o
);
  localparam logic [CNT_W-1:0] FULL_DATA = CNT_W'(1) << CODE_W;

  always_comb begin
    if (mode_i == MODE_BUS)
      len_o = (code_i == '0) ? FULL_DATA + CNT_W'(1) : CNT_W'(code_i) + CNT_W'(1);
    else
      len_o = (code_i == '0) ? FULL_DATA : CNT_W'(code_i);
  end
endmodule

// File: rtl/ser_cnt_code_reg.sv
module ser_cnt_code_reg
  import ser_cnt_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ser_mode_e         mode_i,
  input  logic              wr_en_i,
  input  logic              wr_guard_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic              scl_low_i,
  input  logic              busy_i,
  input  logic              strobe_i,
  input  logic              frame_done_i,
  output logic              wr_ok_o,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_q;

  // clock-line guard applies only to nonzero codes; strobe wins over a write
  assign wr_ok_o = wr_en_i && !wr_guard_i && (mode_i == MODE_BUS)
                && ((wr_code_i == '0) || scl_low_i)
                && !(busy_i && strobe_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           code_q <= '0;
    else if (frame_done_i) code_q <= '0;
    else if (wr_ok_o)      code_q <= wr_code_i;
  end

  assign code_o = code_q;
endmodule

// File: rtl/ser_cnt_down.sv
module ser_cnt_down #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             strobe_i,
  output logic [CNT_W-1:0] rem_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             end_pulse_o
);
  logic [CNT_W-1:0] rem_q;
  logic             end_q;

  assign busy_o = (rem_q != '0);
  assign done_o = busy_o && strobe_i && (rem_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      end_q <= 1'b0;
    end else begin
      end_q <= done_o;
      if (busy_o && strobe_i) rem_q <= rem_q - CNT_W'(1);
      else if (load_i)        rem_q <= load_val_i;
    end
  end

  assign rem_o       = rem_q;
  assign end_pulse_o = end_q;
endmodule

// File: rtl/serial_bit_counter.sv
module serial_bit_counter
  import ser_cnt_pkg::*;
#(
  parameter int CODE_W = 3,
  localparam int CNT_W = CODE_W + 1,
  localparam int REG_W = CODE_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_bus_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             frame_start_i,
  input  logic             bit_strobe_i,
  input  logic             scl_low_i,
  output logic [CNT_W-1:0] remaining_o,
  output logic [CNT_W-1:0] frame_len_o,
  output logic             frame_end_o
);
  ser_mode_e         mode;
  logic [CODE_W-1:0] code_q, next_code, rd_code;
  logic [CNT_W-1:0]  rem, load_len, rem_adj;
  logic              wr_ok, busy, done, load;

  assign mode = ser_mode_e'(mode_bus_i);

  ser_cnt_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk_i, .rst_ni, .mode_i(mode), .wr_en_i,
    .wr_guard_i(wr_data_i[REG_W-1]), .wr_code_i(wr_data_i[CODE_W-1:0]),
    .scl_low_i, .busy_i(busy), .strobe_i(bit_strobe_i),
    .frame_done_i(done), .wr_ok_o(wr_ok), .code_o(code_q)
  );

  assign next_code = wr_ok ? wr_data_i[CODE_W-1:0] : code_q;

  ser_cnt_len_dec #(.CODE_W(CODE_W)) u_dec_cur (
    .mode_i(mode), .code_i(code_q), .len_o(frame_len_o)
  );

  ser_cnt_len_dec #(.CODE_W(CODE_W)) u_dec_next (
    .mode_i(mode), .code_i(next_code), .len_o(load_len)
  );

  // idle start, or accepted rewrite mid-frame
  assign load = (!busy && frame_start_i) || (busy && wr_ok);

  ser_cnt_down #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_len),
    .strobe_i(bit_strobe_i), .rem_o(rem), .busy_o(busy),
    .done_o(done), .end_pulse_o(frame_end_o)
  );

  assign rem_adj = (mode == MODE_BUS) ? rem - CNT_W'(1) : rem;
  assign rd_code = busy ? rem_adj[CODE_W-1:0] : code_q;

  assign rd_data_o   = {1'b1, rd_code};
  assign remaining_o = rem;
endmodule

// File: rtl/serial_bit_counter_chk.sv
module serial_bit_counter_chk #(
  parameter int CODE_W = 3,
  localparam int CNT_W = CODE_W + 1,
  localparam int REG_W = CODE_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_bus_i,
  input logic             frame_start_i,
  input logic             bit_strobe_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic [CNT_W-1:0] remaining_o,
  input logic [CNT_W-1:0] frame_len_o,
  input logic             frame_end_o
);
  always_comb if (rst_ni) p_guard_high_r2: assert (rd_data_o[REG_W-1] == 1'b1);

  p_end_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> !frame_end_o);

  p_end_cleared_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> (remaining_o == '0) && (rd_data_o[CODE_W-1:0] == '0));

  p_decrement_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remaining_o != '0) && bit_strobe_i |=> remaining_o == $past(remaining_o) - CNT_W'(1));

  p_sync_wr_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_bus_i && (remaining_o == '0) && !frame_start_i |=> $stable(rd_data_o));

  p_bus_len_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_bus_i |-> (frame_len_o >= CNT_W'(2)) && (frame_len_o <= (CNT_W'(1) << CODE_W) + CNT_W'(1)));
endmodule

bind serial_bit_counter serial_bit_counter_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i, .rst_ni, .mode_bus_i, .frame_start_i, .bit_strobe_i,
  .rd_data_o, .remaining_o, .frame_len_o, .frame_end_o
);

// File: tb/sim_serial_bit_counter.sv
`timescale 1ns/1ps
module sim_serial_bit_counter;
  logic       clk_i = 0, rst_ni = 0;
  logic       mode_bus_i = 1, wr_en_i = 0, frame_start_i = 0, bit_strobe_i = 0, scl_low_i = 1;
  logic [3:0] wr_data_i = '0;
  logic [3:0] rd_data_o, remaining_o, frame_len_o;
  logic       frame_end_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  serial_bit_counter u0 (.*);

  // {mode_bus, code, expected length}
  localparam logic [7:0] VEC [16] = '{
    {1'b1,3'd0,4'd9}, {1'b1,3'd1,4'd2}, {1'b1,3'd2,4'd3}, {1'b1,3'd3,4'd4},
    {1'b1,3'd4,4'd5}, {1'b1,3'd5,4'd6}, {1'b1,3'd6,4'd7}, {1'b1,3'd7,4'd8},
    {1'b0,3'd0,4'd8}, {1'b0,3'd1,4'd1}, {1'b0,3'd2,4'd2}, {1'b0,3'd3,4'd3},
    {1'b0,3'd4,4'd4}, {1'b0,3'd5,4'd5}, {1'b0,3'd6,4'd6}, {1'b0,3'd7,4'd7}};

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic wr(logic guard, logic [2:0] code, logic scl);
    wr_en_i = 1; wr_data_i = {guard, code}; scl_low_i = scl;
    tick();
    wr_en_i = 0; scl_low_i = 1;
  endtask

  task automatic start();
    frame_start_i = 1; tick(); frame_start_i = 0;
  endtask

  task automatic strobe();
    bit_strobe_i = 1; tick(); bit_strobe_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R10 reset state
    chk("R10 rd", rd_data_o, 8'h8);
    chk("R10 rem", remaining_o, 0);
    chk("R10 end", frame_end_o, 0);
    rst_ni = 1; tick();

    // R3 R4 decode table, R2 guard readback
    for (int i = 0; i < 16; i++) begin
      mode_bus_i = 1;
      wr(0, VEC[i][6:4], 1);
      mode_bus_i = VEC[i][7];
      #1;
      chk(VEC[i][7] ? "R3 len" : "R4 len", frame_len_o, VEC[i][3:0]);
      chk("R2 rd", rd_data_o, {1'b1, VEC[i][6:4]});
    end
    mode_bus_i = 1;

    // R7 clock-line guard
    wr(0, 3'd0, 1);
    wr(0, 3'd3, 0);
    chk("R7 nonzero scl high", rd_data_o, 8'h8);
    wr(0, 3'd5, 1);
    chk("R7 nonzero scl low", rd_data_o, 8'hD);
    wr(0, 3'd0, 0);
    chk("R7 zero scl high", rd_data_o, 8'h8);

    // R1 guard write protection
    wr(1, 3'd6, 1);
    chk("R1 guard set", rd_data_o, 8'h8);
    wr(0, 3'd6, 1);
    chk("R1 guard clear", rd_data_o, 8'hE);
    wr(0, 3'd0, 1);

    // R11 strobe while idle
    strobe();
    chk("R11 idle strobe rem", remaining_o, 0);
    chk("R11 idle strobe end", frame_end_o, 0);

    // full bus frame, 9 bits
    start();
    chk("R11 bus load", remaining_o, 9);
    chk("R5 bus full", rd_data_o, 8'h8);
    for (int k = 1; k <= 9; k++) begin
      bit_strobe_i = 1; tick();
      if (k == 1) chk("R5 bus 8 left", rd_data_o, 8'hF);
      if (k == 9) begin
        chk("R6 bus end pulse", frame_end_o, 1);
        chk("R6 bus rem", remaining_o, 0);
        chk("R6 bus code", rd_data_o, 8'h8);
      end
    end
    bit_strobe_i = 0; tick();
    chk("R6 pulse width", frame_end_o, 0);

    // bus frame code 3: R9 and busy-start
    wr(0, 3'd3, 1);
    start();
    chk("R11 bus4 load", remaining_o, 4);
    chk("R5 bus4 rd", rd_data_o, 8'hB);
    strobe();
    chk("R5 bus3 rd", rd_data_o, 8'hA);
    bit_strobe_i = 1; wr_en_i = 1; wr_data_i = 4'h6; tick();
    bit_strobe_i = 0; wr_en_i = 0;
    chk("R9 strobe wins rem", remaining_o, 2);
    chk("R9 strobe wins rd", rd_data_o, 8'h9);
    start();
    chk("R11 busy start", remaining_o, 2);
    wr(0, 3'd4, 1);
    chk("R9 reload", remaining_o, 5);
    repeat (4) strobe();
    bit_strobe_i = 1; tick(); bit_strobe_i = 0;
    chk("R6 bus4 end", frame_end_o, 1);
    chk("R6 code zero", rd_data_o, 8'h8);
    tick();

    // sync frame, 8 bits
    mode_bus_i = 0;
    wr(0, 3'd5, 1);
    chk("R8 sync idle write", rd_data_o, 8'h8);
    start();
    chk("R11 sync load", remaining_o, 8);
    chk("R5 sync full", rd_data_o, 8'h8);
    strobe();
    chk("R5 sync 7 left", rd_data_o, 8'hF);
    wr(0, 3'd2, 1);
    chk("R8 sync busy write", remaining_o, 7);
    repeat (6) strobe();
    bit_strobe_i = 1; tick(); bit_strobe_i = 0;
    chk("R6 sync end", frame_end_o, 1);
    chk("R6 sync rem", remaining_o, 0);
    tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule